// File: doc/BRIEF.md
# Two-Tier Interrupt Aggregation Controller

This block gathers interrupt requests from a set of internal sources into one status register and one enable register, and turns them into a single combined interrupt request. That request is a level signal for a separate pin-conditioning stage. There are two kinds of source. A direct source latches an event into a sticky status bit owned by this block. Software clears that bit here by writing a one to it. A summary source only reflects a pending flag held in some sub-module's own register. Its status bit follows that flag and cannot be cleared from here. Software reads the sub-module to find out which event fired, and clears the flag there.

Software reaches the block through a simple register port with an address, a write strobe, write data and combinational read data. There are three locations: the status register, the enable register, and a write-only location used to raise the software interrupt on purpose. The direct bits sit at the low end of status and enable, and the summary bits sit above them.

Top module: `intr_agg_top`

## Requirements
- R1: After reset the direct status bits, the enable register and the interrupt request are all 0.
- R2: A 1 on `dir_evt[i]` at a clock edge sets direct status bit i (status bit i, read at address 0). The bit stays 1 until it is cleared by software.
- R3: A write to address 0 clears each direct status bit whose write-data bit is 1. Direct bits whose write-data bit is 0 keep their value.
- R4: If a set event and a clear of the same direct bit arrive at the same edge, the bit ends up 1.
- R5: Summary status bit j (status bit N_DIR+j) equals `sum_src[j]` as sampled at the previous edge.
- R6: Writes to address 0 have no effect on the summary bits.
- R7: A write to address 1 loads the enable register. Reads at address 1 return it. Reads at address 2 return 0.
- R8: A write to address 2 with write-data bit 0 set to 1 sets direct status bit SW_IDX. Address 2 affects nothing else.
- R9: `irq_req` is 1 exactly one cycle after a cycle in which some status bit and its enable bit are both 1. A source whose enable bit is 0 never raises the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_evt | input | N_DIR | Event pulses from the direct sources |
| sum_src | input | N_SUM | Pending flags from the sub-module registers |
| reg_addr | input | 2 | Register select: 0 status, 1 enable, 2 software raise |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | N_DIR+N_SUM | Write data |
| reg_rdata | output | N_DIR+N_SUM | Read data for the selected register |
| irq_req | output | 1 | Registered combined interrupt request |

## Verification
The bench builds the block with three direct sources and six summary sources, and puts the software source at index 1. This puts the software bit in the middle of the direct field rather than at an edge, so a wrong shift of the raise bit shows up. The wider summary field also moves the boundary between direct and summary bits away from the default. Random traffic mixes event pulses, clears, enable writes and summary flag changes. Directed cases cover an event and a clear on the same bit in the same cycle, writes of ones aimed at the summary bits, and sources that are pending while masked.

// File: rtl/intr_agg_pkg.sv
// Package: shared register selector encoding for the interrupt aggregator.
// Assumes a two-bit register address on the access port.
package intr_agg_pkg;
    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_SWSET  = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/intr_direct_bank.sv
// Module: sticky status bits for direct interrupt sources.
// Each bit is set by a hardware event pulse and cleared by a clear mask.
// A set and a clear in the same cycle leave the bit set.
// Bit SW_IDX can also be set by a software raise strobe.
// Assumes the clear mask is already qualified by the register write decode.
module intr_direct_bank #(
    parameter int N      = 4,
    parameter int SW_IDX = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hw_evt,
    input  logic [N-1:0] clr_mask,
    input  logic         sw_raise,
    output logic [N-1:0] stat
);
    logic [N-1:0] set_vec;

    // Merge the hardware events with the software raise at its bit position.
    always_comb begin
        set_vec         = hw_evt;
        set_vec[SW_IDX] = hw_evt[SW_IDX] | sw_raise;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Per-bit sticky flag: reset clears it, and set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stat[i] <= 1'b0;
            else if (set_vec[i])
                stat[i] <= 1'b1;
            else if (clr_mask[i])
                stat[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/intr_summary_mirror.sv
// Module: one-cycle registered copy of the pending flags held in sub-modules.
// There is no local clear. Each bit follows its source flag.
// Assumes the source flags are synchronous to clk.
module intr_summary_mirror #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src,
    output logic [N-1:0] mirror
);
    // Sample the sub-module flags each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mirror <= '0;
        else
            mirror <= src;
    end
endmodule

// File: rtl/intr_combine.sv
// Module: reduces status AND enable to a single registered request.
// Assumes status and enable are aligned bit for bit.
module intr_combine #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] stat,
    input  logic [W-1:0] en,
    output logic         irq
);
    logic any_pending;

    // OR over all enabled pending bits.
    always_comb any_pending = |(stat & en);

    // Register the request for a glitch-free level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= any_pending;
    end
endmodule

// File: rtl/intr_agg_top.sv
// Module: top of the two-tier interrupt aggregation controller.
// Direct bits occupy status[N_DIR-1:0] and summary bits occupy the bits above.
// Register port: address 0 status (write 1 clears direct bits), address 1
// enable (read and write), address 2 write-only software raise (data bit 0).
// Assumes a single-cycle write strobe and a combinational read.
module intr_agg_top #(
    parameter int N_DIR  = 4,
    parameter int N_SUM  = 5,
    parameter int SW_IDX = 0,
    localparam int TOT_W = N_DIR + N_SUM
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DIR-1:0] dir_evt,
    input  logic [N_SUM-1:0] sum_src,
    input  logic [1:0]       reg_addr,
    input  logic             reg_we,
    input  logic [TOT_W-1:0] reg_wdata,
    output logic [TOT_W-1:0] reg_rdata,
    output logic             irq_req
);
    import intr_agg_pkg::*;

    reg_sel_e         sel;
    logic [N_DIR-1:0] clr_mask;
    logic             sw_raise;
    logic             en_wr;
    logic [N_DIR-1:0] dir_stat;
    logic [N_SUM-1:0] sum_stat;
    logic [TOT_W-1:0] status;
    logic [TOT_W-1:0] enable_q;

    // Decode the register access into per-function strobes.
    always_comb begin
        sel      = reg_sel_e'(reg_addr);
        clr_mask = (reg_we && sel == SEL_STATUS) ? reg_wdata[N_DIR-1:0] : '0;
        sw_raise = reg_we && sel == SEL_SWSET && reg_wdata[0];
        en_wr    = reg_we && sel == SEL_ENABLE;
    end

    intr_direct_bank #(.N(N_DIR), .SW_IDX(SW_IDX)) u_direct (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_evt   (dir_evt),
        .clr_mask (clr_mask),
        .sw_raise (sw_raise),
        .stat     (dir_stat)
    );

    intr_summary_mirror #(.N(N_SUM)) u_summary (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (sum_src),
        .mirror (sum_stat)
    );

    // Assemble the full status word.
    always_comb status = {sum_stat, dir_stat};

    // Enable register: cleared by reset, loaded by a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable_q <= '0;
        else if (en_wr)
            enable_q <= reg_wdata;
    end

    intr_combine #(.W(TOT_W)) u_combine (
        .clk   (clk),
        .rst_n (rst_n),
        .stat  (status),
        .en    (enable_q),
        .irq   (irq_req)
    );

    // Read multiplexer for the selected register.
    always_comb begin
        case (sel)
            SEL_STATUS: reg_rdata = status;
            SEL_ENABLE: reg_rdata = enable_q;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/intr_agg_checker.sv
// Checker: temporal properties of the interrupt aggregator, seen from its ports
// and from the status and enable words that separate logic drives.
// It is attached to every instance of the top module by the bind below.
module intr_agg_checker #(
    parameter int N_DIR  = 4,
    parameter int N_SUM  = 5,
    parameter int SW_IDX = 0,
    localparam int TOT_W = N_DIR + N_SUM
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_DIR-1:0] dir_evt,
    input logic [N_SUM-1:0] sum_src,
    input logic [1:0]       reg_addr,
    input logic             reg_we,
    input logic [TOT_W-1:0] reg_wdata,
    input logic [TOT_W-1:0] status,
    input logic [TOT_W-1:0] enable_q,
    input logic             irq_req
);
    logic             past_ok;
    logic [N_DIR-1:0] wr_clr;
    logic [N_DIR-1:0] any_set;
    logic [N_DIR-1:0] dir_bits;

    // Marks the cycles in which $past refers to a cycle out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            past_ok <= 1'b0;
        else
            past_ok <= 1'b1;
    end

    // Observed clear requests and set requests, as seen at the port.
    always_comb begin
        wr_clr           = (reg_we && reg_addr == 2'd0) ? reg_wdata[N_DIR-1:0] : '0;
        any_set          = dir_evt;
        any_set[SW_IDX]  = dir_evt[SW_IDX] | (reg_we && reg_addr == 2'd2 && reg_wdata[0]);
        dir_bits         = status[N_DIR-1:0];
    end

    p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        1 |=> ((($past(dir_bits) & ~$past(wr_clr)) & ~dir_bits) == '0));

    p_clear_takes_r3: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        1 |=> ((dir_bits & $past(wr_clr & ~any_set)) == '0));

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (any_set != '0) |=> ((dir_bits & $past(any_set)) == $past(any_set)));

    p_summary_follows_r5: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        1 |=> (status[TOT_W-1:N_DIR] == $past(sum_src)));

    p_request_timing_r9: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        1 |=> (irq_req == $past(|(status & enable_q))));

    // R1: right after reset, the request is low.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !irq_req);
endmodule

bind intr_agg_top intr_agg_checker #(.N_DIR(N_DIR), .N_SUM(N_SUM), .SW_IDX(SW_IDX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_evt   (dir_evt),
    .sum_src   (sum_src),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .status    (status),
    .enable_q  (enable_q),
    .irq_req   (irq_req)
);

// File: tb/intr_agg_top_tb_top.sv
// Bench: constrained random plus directed cases, against a bench-side model.
module intr_agg_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ND  = 3;
    localparam int NS  = 6;
    localparam int SWI = 1;
    localparam int TW  = ND + NS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [ND-1:0] dir_evt = '0;
    logic [NS-1:0] sum_src = '0;
    logic [1:0]    reg_addr = '0;
    logic          reg_we = 1'b0;
    logic [TW-1:0] reg_wdata = '0;
    logic [TW-1:0] reg_rdata;
    logic          irq_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Bench-side model state
    logic [ND-1:0] m_dir = '0;
    logic [NS-1:0] m_sum = '0;
    logic [TW-1:0] m_en  = '0;
    logic          m_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_agg_top #(.N_DIR(ND), .N_SUM(NS), .SW_IDX(SWI)) dut_i (
        .clk(clk), .rst_n(rst_n), .dir_evt(dir_evt), .sum_src(sum_src),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req)
    );

    task automatic check(input string tag, input logic [TW-1:0] act, input logic [TW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [TW-1:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return {m_sum, m_dir};
            2'd1:    return m_en;
            default: return '0;
        endcase
    endfunction

    // Apply the current inputs across one clock edge and advance the model.
    task automatic step();
        logic [ND-1:0] clr;
        logic [ND-1:0] setv;
        clr  = (reg_we && reg_addr == 2'd0) ? reg_wdata[ND-1:0] : '0;
        setv = dir_evt;
        if (reg_we && reg_addr == 2'd2 && reg_wdata[0]) setv[SWI] = 1'b1;
        @(posedge clk);
        m_irq = |({m_sum, m_dir} & m_en);
        m_dir = (m_dir & ~clr) | setv;
        m_sum = sum_src;
        if (reg_we && reg_addr == 2'd1) m_en = reg_wdata;
        @(negedge clk);
        dir_evt = '0; reg_we = 1'b0;
    endtask

    // Compare the request and a status read with the model.
    task automatic check_state(input string tag);
        check({tag, " irq (R9)"}, TW'(irq_req), TW'(m_irq));
        reg_addr = 2'd0; #1;
        check({tag, " status"}, reg_rdata, exp_read(2'd0));
    endtask

    task automatic wr(input logic [1:0] a, input logic [TW-1:0] d);
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        reg_addr = 2'd0; #1;
        check("R1 status after reset", reg_rdata, '0);
        reg_addr = 2'd1; #1;
        check("R1 enable after reset", reg_rdata, '0);
        check("R1 irq after reset", TW'(irq_req), '0);

        // R2: sticky direct bit, masked so R9 no request
        dir_evt = 3'b100; step();
        step(); step();
        check_state("R2 sticky");
        check("R9 masked no request", TW'(irq_req), '0);

        // R3: clear writes, 0 bits keep value
        dir_evt = 3'b011; step();
        wr(2'd0, TW'(3'b001)); step();
        check_state("R3 partial clear");

        // R4: set and clear same edge
        dir_evt = 3'b001; wr(2'd0, TW'(3'b111)); step();
        check_state("R4 set wins");

        // R5 and R6: summary mirror, writes of ones to summary ignored
        sum_src = 6'b101101; step();
        wr(2'd0, {NS'('1), ND'(0)}); step();
        check_state("R5 R6 summary kept");
        sum_src = 6'b000000; step();
        check_state("R5 summary follows source");

        // R7: enable readback, address 2 reads 0
        wr(2'd1, TW'(9'h1a5)); step();
        reg_addr = 2'd1; #1;
        check("R7 enable readback", reg_rdata, TW'(9'h1a5));
        reg_addr = 2'd2; #1;
        check("R7 address 2 reads zero", reg_rdata, '0);

        // R8: software raise of bit SWI
        wr(2'd0, TW'(3'b111)); step();
        wr(2'd2, TW'(1)); step();
        check_state("R8 software raise");
        wr(2'd2, TW'(9'h1fe)); step();
        check_state("R8 bit0 zero no raise");

        // R9: enabled pending gives request one cycle later
        wr(2'd1, TW'(1 << SWI)); step();
        check_state("R9 request");
        step();
        check_state("R9 request held");

        // Random traffic against the model (R2 R3 R4 R5 R7 R9)
        for (int k = 0; k < 3000; k++) begin
            dir_evt = ND'($urandom_range(0, 7)) & (($urandom_range(0, 3) == 0) ? '1 : '0);
            if ($urandom_range(0, 3) == 0) sum_src = NS'($urandom);
            reg_addr  = 2'($urandom_range(0, 3));
            reg_we    = ($urandom_range(0, 2) == 0);
            reg_wdata = TW'($urandom);
            #1;
            check("R7 random read", reg_rdata, exp_read(reg_addr));
            step();
            check_state("R2 R3 R4 R5 random");
        end
        done = 1'b1;
    end

    // Watchdog and final summary
    initial begin
        fork
            begin wait (done); end
            begin
                repeat (100000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule